// File: doc/BRIEF.md
# Ray to Cube-Face Address Converter

This block is a pipelined stage that takes a 3-D direction vector and finds where the ray from the origin leaves an axis-aligned cube whose faces sit at ±1.0. It returns the face that is hit and the two coordinates of the hit point on that face, as 9-bit values for a 512×512 face grid. It also returns four finer fraction bits per coordinate, which a later interpolation filter can use.

Each axis is tried in parallel as the major (dividing) axis. The block does not use a divider. Each axis magnitude indexes a reciprocal table that is computed at elaboration. The reciprocal is then multiplied by the other two magnitudes. An axis qualifies when both of its quotients lie strictly inside (−1, 1). The first qualifying axis in the order X, Y, Z wins. The sign of that axis component then picks one of its two faces.

The table entries are rounded down and carry extra low-order bits. As a result the true largest axis always qualifies, and an exact tie never leaves the block without a face. The block accepts one vector per clock, has a fixed latency and passes a valid flag along with the data.

Top module: `ray_face_addr`

## Requirements
- R1: Each input component is a signed 16-bit fixed-point value with 14 fraction bits, so 1.0 = 16384. Components lie in [−16384, 16384]. When in_valid is high, one vector is accepted on every rising clock edge.
- R2: out_valid equals in_valid as sampled exactly three rising edges earlier. While rst_n is low, every output is cleared to zero at the clock edge.
- R3: The face goes to the axis with the largest magnitude. This holds when that magnitude is at least 0.25 and exceeds the other two by more than 3 %. Face codes are +X=0, −X=1, +Y=2, −Y=3, +Z=4, −Z=5. A component whose sign bit is 0 selects the plus face.
- R4: For every in-range vector, at least one axis passes the range check. The axis of largest magnitude always passes. Every valid output therefore carries a face code from 0 to 5.
- R5: When two or three magnitudes are equal and largest, X is chosen before Y and Y before Z. This also holds at magnitude 1.0.
- R6: The coordinates are i=Vy/Vx and j=Vz/Vx on the X faces, i=Vx/Vy and j=Vz/Vy on the Y faces, and i=Vx/Vz and j=Vy/Vz on the Z faces. Each 9-bit coordinate is within 2 of (q+1)·256 saturated to 0..511, where q is the signed quotient.
- R7: The 4-bit fraction output holds the bits just below the coordinate. The 13-bit value {coordinate, fraction} is within 40 of (q+1)·4096 saturated to 8191.
- R8: The zero vector yields face 0, both coordinates 256 and both fractions 0.
- R9: Vectors presented on consecutive cycles are handled independently. A cycle with in_valid low produces a cycle with out_valid low three edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector present |
| in_vx | input | 16 | X component, signed, 14 fraction bits |
| in_vy | input | 16 | Y component, signed, 14 fraction bits |
| in_vz | input | 16 | Z component, signed, 14 fraction bits |
| out_valid | output | 1 | Result present |
| out_face | output | 3 | Face code 0..5 |
| out_i | output | 9 | First face coordinate |
| out_j | output | 9 | Second face coordinate |
| out_i_frac | output | 4 | Fraction bits below out_i |
| out_j_frac | output | 4 | Fraction bits below out_j |

## Verification
Single-axis vectors of full magnitude on all six faces confirm the face encoding and the centre coordinate. The zero vector pins down the degenerate divisor. Exact two-way and three-way ties, including ties at 1.0 and ties of opposite sign, separate correct X-before-Y-before-Z priority from a design that drops the face or saturates the wrong way. Random vectors with a clear major axis, random signs and random gaps in in_valid compare coordinates and fractions with real-valued quotients, which exposes errors in numerator selection, sign handling and pipeline alignment.

// File: rtl/ray_face_pkg.sv
`timescale 1ns/1ps
// Package: shared widths and the reciprocal table entry function for the
// ray to cube-face converter. Assumes unit-scale inputs (1.0 = 2**FRAC_W).
package ray_face_pkg;
    parameter int COMP_W  = 16;  // input component width
    parameter int FRAC_W  = 14;  // fraction bits of a component
    parameter int RIDX_W  = 10;  // reciprocal table index width
    parameter int XTRA_W  = 4;   // extra quotient bits below the component lsb
    parameter int COORD_W = 9;   // face coordinate width
    parameter int FILT_W  = 4;   // exported fraction bits
    parameter int FACE_W  = 3;   // face code width

    localparam int BIN_SHIFT = FRAC_W - RIDX_W;
    localparam int RDEPTH    = 1 << RIDX_W;
    localparam int RECIP_K   = 2 * FRAC_W;
    localparam int RECIP_W   = RECIP_K - BIN_SHIFT + 1;
    localparam int Q_W       = FRAC_W + XTRA_W;
    localparam int PROD_W    = COMP_W + RECIP_W;
    localparam int QSHIFT    = RECIP_K - Q_W;
    localparam int U_W       = Q_W + 1;
    localparam int COORD_LSB = U_W - COORD_W;
    localparam int FRAC_LSB  = COORD_LSB - FILT_W;
    localparam int TOP_W     = U_W - FRAC_LSB;

    // Rounded-down reciprocal of the upper edge of bin k (plus one), so the
    // entry never exceeds the true reciprocal of any magnitude in the bin.
    function automatic logic [RECIP_W-1:0] recip_entry(int unsigned k);
        longint unsigned den;
        den = ((longint'(k) + 1) << BIN_SHIFT) + 1;
        return RECIP_W'((longint'(1) << RECIP_K) / den);
    endfunction
endpackage

// File: rtl/ray_recip_rom.sv
`timescale 1ns/1ps
// Module: reciprocal lookup table, filled at elaboration from recip_entry.
// Assumes the index is already clamped to the table depth. Combinational.
module ray_recip_rom
    import ray_face_pkg::*;
(
    input  logic [RIDX_W-1:0]  idx,
    output logic [RECIP_W-1:0] recip
);
    logic [RECIP_W-1:0] table_q [RDEPTH];

    // Table contents: one computed constant per bin.
    for (genvar k = 0; k < RDEPTH; k++) begin : g_entry
        assign table_q[k] = recip_entry(k);
    end

    // Table read.
    assign recip = table_q[idx];
endmodule

// File: rtl/ray_axis_quotient.sv
`timescale 1ns/1ps
// Module: one candidate axis. Multiplies the two numerator magnitudes by the
// axis reciprocal and flags whether both quotients lie strictly below 1.0.
// Assumes unsigned magnitudes; signs are handled downstream. One register stage.
module ray_axis_quotient
    import ray_face_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COMP_W-1:0]  num0_mag,
    input  logic [COMP_W-1:0]  num1_mag,
    input  logic [RECIP_W-1:0] recip,
    output logic [Q_W-1:0]     q0,
    output logic [Q_W-1:0]     q1,
    output logic               ok
);
    logic [PROD_W-1:0] full0, full1;

    // Quotients with Q_W fraction bits: product scaled down by QSHIFT.
    always_comb begin
        full0 = (PROD_W'(num0_mag) * PROD_W'(recip)) >> QSHIFT;
        full1 = (PROD_W'(num1_mag) * PROD_W'(recip)) >> QSHIFT;
    end

    // Register the quotient fractions and the strict range check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q0 <= '0;
            q1 <= '0;
            ok <= 1'b0;
        end else begin
            q0 <= full0[Q_W-1:0];
            q1 <= full1[Q_W-1:0];
            ok <= (full0[PROD_W-1:Q_W] == '0) && (full1[PROD_W-1:Q_W] == '0);
        end
    end
endmodule

// File: rtl/ray_face_select.sv
`timescale 1ns/1ps
// Module: picks the first qualifying axis (X, then Y, then Z), forms the face
// code from its sign, and maps both signed quotients to coordinates.
// Assumes at least one axis qualifies for in-range inputs. One register stage.
module ray_face_select
    import ray_face_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [2:0]                 ok,
    input  logic [2:0][1:0][Q_W-1:0]   q,
    input  logic [2:0]                 neg,
    output logic                       out_valid,
    output logic [FACE_W-1:0]          out_face,
    output logic [COORD_W-1:0]         out_i,
    output logic [COORD_W-1:0]         out_j,
    output logic [FILT_W-1:0]          out_i_frac,
    output logic [FILT_W-1:0]          out_j_frac
);
    localparam logic [U_W-1:0] UNITY = U_W'(1) << Q_W;

    logic [1:0]       sel;
    logic [Q_W-1:0]   qa, qb;
    logic             na, nb, nd;
    logic [U_W-1:0]   ua, ub;
    logic [TOP_W-1:0] ta, tb;

    // Priority pick of the major axis and routing of its numerators.
    always_comb begin
        if (ok[0])      sel = 2'd0;
        else if (ok[1]) sel = 2'd1;
        else if (ok[2]) sel = 2'd2;
        else            sel = 2'd0;
        case (sel)
            2'd1: begin qa = q[1][0]; qb = q[1][1]; na = neg[0]; nb = neg[2]; nd = neg[1]; end
            2'd2: begin qa = q[2][0]; qb = q[2][1]; na = neg[0]; nb = neg[1]; nd = neg[2]; end
            default: begin qa = q[0][0]; qb = q[0][1]; na = neg[1]; nb = neg[2]; nd = neg[0]; end
        endcase
        ua = (na ^ nd) ? (UNITY - U_W'(qa)) : (UNITY + U_W'(qa));
        ub = (nb ^ nd) ? (UNITY - U_W'(qb)) : (UNITY + U_W'(qb));
        ta = TOP_W'(ua >> FRAC_LSB);
        tb = TOP_W'(ub >> FRAC_LSB);
    end

    // Output register: face code, coordinates and fraction bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_face   <= '0;
            out_i      <= '0;
            out_j      <= '0;
            out_i_frac <= '0;
            out_j_frac <= '0;
        end else begin
            out_valid  <= in_valid;
            out_face   <= {sel, neg[sel]};
            out_i      <= ta[TOP_W-1:FILT_W];
            out_j      <= tb[TOP_W-1:FILT_W];
            out_i_frac <= ta[FILT_W-1:0];
            out_j_frac <= tb[FILT_W-1:0];
        end
    end

    // A valid vector always reaches this stage with some qualifying axis.
    assert_major_found_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (ok != 3'b000));

    // When X qualifies it wins over Y and Z.
    assert_x_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ok[0]) |=> (out_face[2:1] == 2'd0));
endmodule

// File: rtl/ray_face_addr.sv
`timescale 1ns/1ps
// Module: top of the ray to cube-face converter. Stage 1 takes magnitudes,
// signs and reciprocals; stage 2 forms the quotients; stage 3 selects the face.
// Assumes components within [-1.0, 1.0]. Latency three clocks, one vector per clock.
module ray_face_addr
    import ray_face_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [COMP_W-1:0] in_vx,
    input  logic signed [COMP_W-1:0] in_vy,
    input  logic signed [COMP_W-1:0] in_vz,
    output logic                     out_valid,
    output logic [FACE_W-1:0]        out_face,
    output logic [COORD_W-1:0]       out_i,
    output logic [COORD_W-1:0]       out_j,
    output logic [FILT_W-1:0]        out_i_frac,
    output logic [FILT_W-1:0]        out_j_frac
);
    logic [2:0][COMP_W-1:0]  in_vec, in_mag, s1_mag;
    logic [2:0][RIDX_W-1:0]  in_idx;
    logic [2:0][RECIP_W-1:0] rom_out, s1_recip;
    logic [2:0]              s1_neg, s2_neg, q_ok;
    logic                    s1_valid, s2_valid;
    logic [2:0][1:0][Q_W-1:0] q_pair;

    assign in_vec = {in_vz, in_vy, in_vx};

    // Magnitudes and clamped table indices of the incoming components.
    always_comb begin
        for (int a = 0; a < 3; a++) begin
            logic [COMP_W-1:0] bin;
            in_mag[a] = in_vec[a][COMP_W-1] ? COMP_W'(-in_vec[a]) : in_vec[a];
            bin = in_mag[a] >> BIN_SHIFT;
            in_idx[a] = (bin > COMP_W'(RDEPTH - 1)) ? RIDX_W'(RDEPTH - 1) : bin[RIDX_W-1:0];
        end
    end

    // Per-axis reciprocal table and quotient stage.
    for (genvar a = 0; a < 3; a++) begin : g_axis
        localparam int N0 = (a == 0) ? 1 : 0;
        localparam int N1 = (a == 2) ? 1 : 2;
        ray_recip_rom u_rom (
            .idx   (in_idx[a]),
            .recip (rom_out[a])
        );
        ray_axis_quotient u_quo (
            .clk      (clk),
            .rst_n    (rst_n),
            .num0_mag (s1_mag[N0]),
            .num1_mag (s1_mag[N1]),
            .recip    (s1_recip[a]),
            .q0       (q_pair[a][0]),
            .q1       (q_pair[a][1]),
            .ok       (q_ok[a])
        );
    end

    // Stage 1 register: magnitudes, signs, reciprocals, valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_mag   <= '0;
            s1_neg   <= '0;
            s1_recip <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_mag   <= in_mag;
            s1_neg   <= {in_vz[COMP_W-1], in_vy[COMP_W-1], in_vx[COMP_W-1]};
            s1_recip <= rom_out;
        end
    end

    // Stage 2 register: signs and valid alongside the quotients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_neg   <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_neg   <= s1_neg;
        end
    end

    ray_face_select u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (s2_valid),
        .ok         (q_ok),
        .q          (q_pair),
        .neg        (s2_neg),
        .out_valid  (out_valid),
        .out_face   (out_face),
        .out_i      (out_i),
        .out_j      (out_j),
        .out_i_frac (out_i_frac),
        .out_j_frac (out_j_frac)
    );

    // Valid flag travels with the data for exactly three edges.
    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);
    assert_gap_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // The X candidate qualifies whenever X has the largest magnitude.
    assert_max_axis_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_mag[0] >= s1_mag[1] && s1_mag[0] >= s1_mag[2]) |=> q_ok[0]);
endmodule

// File: tb/test_ray_face_addr.sv
`timescale 1ns/1ps
module test_ray_face_addr;
    localparam int N = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic signed [15:0] in_vx = '0, in_vy = '0, in_vz = '0;
    logic        out_valid;
    logic [2:0]  out_face;
    logic [8:0]  out_i, out_j;
    logic [3:0]  out_i_frac, out_j_frac;

    logic signed [15:0] tx [N];
    logic signed [15:0] ty [N];
    logic signed [15:0] tz [N];
    bit                 tv [N];
    string              tag [N];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    ray_face_addr i_ray_face_addr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_vx(in_vx), .in_vy(in_vy), .in_vz(in_vz),
        .out_valid(out_valid), .out_face(out_face),
        .out_i(out_i), .out_j(out_j),
        .out_i_frac(out_i_frac), .out_j_frac(out_j_frac)
    );

    task automatic chk(bit good, string req, string what, int act, int expv);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    function automatic int mag(int v);
        return (v < 0) ? -v : v;
    endfunction

    // Coordinate check of one signed quotient against the real value (R6, R7).
    task automatic chk_coord(int num, int den, int c, int f, string name);
        real s, e9, e13, d;
        int v13;
        s   = (den == 0) ? 0.0 : real'(num) / real'(den);
        e9  = (s + 1.0) * 256.0;
        if (e9 > 511.0) e9 = 511.0;
        d = real'(c) - e9;
        chk(d <= 2.0 && d >= -2.0, "R6", name, c, $rtoi(e9));
        e13 = (s + 1.0) * 4096.0;
        if (e13 > 8191.0) e13 = 8191.0;
        v13 = c * 16 + f;
        d = real'(v13) - e13;
        chk(d <= 40.0 && d >= -40.0, "R7", {name, " with fraction"}, v13, $rtoi(e13));
    endtask

    task automatic check_entry(int k);
        int x, y, z, face, na, nb, den;
        if (!tv[k]) begin
            chk(out_valid == 1'b0, "R9", "out_valid on gap", int'(out_valid), 0);
            return;
        end
        chk(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
        x = tx[k]; y = ty[k]; z = tz[k];
        if (mag(x) >= mag(y) && mag(x) >= mag(z)) begin
            face = (x < 0) ? 1 : 0; na = y; nb = z; den = x;
        end else if (mag(y) >= mag(z)) begin
            face = (y < 0) ? 3 : 2; na = x; nb = z; den = y;
        end else begin
            face = (z < 0) ? 5 : 4; na = x; nb = y; den = z;
        end
        chk(int'(out_face) == face, tag[k], "face", int'(out_face), face);
        chk_coord(na, den, int'(out_i), int'(out_i_frac), "out_i");
        chk_coord(nb, den, int'(out_j), int'(out_j_frac), "out_j");
        if (tag[k] == "R8")
            chk(out_i == 9'd256 && out_j == 9'd256 && out_i_frac == 4'd0 && out_j_frac == 4'd0,
                "R8", "zero vector centre", int'(out_i), 256);
    endtask

    task automatic set_vec(int k, int x, int y, int z, string t);
        tx[k] = 16'(x); ty[k] = 16'(y); tz[k] = 16'(z); tv[k] = 1'b1; tag[k] = t;
    endtask

    initial begin
        void'($urandom(32'd4242));
        // Directed corners.
        set_vec(0, 0, 0, 0, "R8");
        set_vec(1, 16384, 0, 0, "R3");
        set_vec(2, 0, -16384, 0, "R3");
        set_vec(3, 0, 0, 16384, "R3");
        set_vec(4, -16384, 0, 0, "R3");
        set_vec(5, 0, 16384, 0, "R3");
        set_vec(6, 0, 0, -16384, "R3");
        set_vec(7, 12000, 12000, 3000, "R5");
        set_vec(8, 1000, -9000, 9000, "R5");
        set_vec(9, -10000, -10000, -10000, "R5");
        set_vec(10, 16384, 16384, 16384, "R5");
        set_vec(11, 16384, -16384, 5000, "R5");
        set_vec(12, 0, 0, 0, "R9"); tv[12] = 1'b0;
        set_vec(13, 8192, 4096, -2048, "R6");
        // Random vectors, R1: every magnitude kept within 1.0, major axis clear by 3 %.
        for (int k = 14; k < N; k++) begin
            int ax, m, o1, o2, lim;
            int v [3];
            ax  = int'($urandom % 3);
            m   = 8192 + int'($urandom % 8193);
            lim = (m * 97) / 100;
            o1  = int'($urandom % (lim + 1));
            o2  = int'($urandom % (lim + 1));
            v[ax]           = ($urandom % 2) ? -m : m;
            v[(ax + 1) % 3] = ($urandom % 2) ? -o1 : o1;
            v[(ax + 2) % 3] = ($urandom % 2) ? -o2 : o2;
            set_vec(k, v[0], v[1], v[2], "R3");
            tv[k] = (($urandom % 5) != 0);
        end

        // Reset state (R2).
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R2", "reset out_valid", int'(out_valid), 0);
        chk(out_face == 3'd0 && out_i == 9'd0 && out_j == 9'd0, "R2", "reset outputs",
            int'(out_face) + int'(out_i) + int'(out_j), 0);
        chk(out_i_frac == 4'd0 && out_j_frac == 4'd0, "R2", "reset fractions",
            int'(out_i_frac) + int'(out_j_frac), 0);
        rst_n = 1'b1;

        // Stream: sample result of entry k-3, then drive entry k (R9 back to back).
        for (int k = 0; k < N + 3; k++) begin
            @(negedge clk);
            if (k >= 3) check_entry(k - 3);
            else chk(out_valid == 1'b0, "R2", "pipeline empty", int'(out_valid), 0);
            if (k < N) begin
                in_valid = tv[k]; in_vx = tx[k]; in_vy = ty[k]; in_vz = tz[k];
            end else begin
                in_valid = 1'b0;
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule